// File: doc/BRIEF.md
# Word-Aligned Program Counter and Next-Address Selector

This block holds the program counter of a single-cycle 32-bit processor and chooses, on every clock, which address is fetched next. Instructions are always four bytes long and word aligned, so only the upper 30 bits of the counter are stored. All target arithmetic is done in word units, and the two low address bits are tied to zero at the output.

Three candidate addresses are formed in parallel:

- the following word in sequence;
- a PC-relative branch target;
- a jump target that keeps the top four address bits of the current counter.

A jump strobe overrides everything else. A branch is taken only when the branch strobe and the ALU zero flag are both high. A small instruction store inside the block supplies the word at the current address. The same word feeds the branch and jump fields, and it is also driven out for the decoder. The store is filled through a synchronous write port.

Top module: `fetch_pc_unit`

## Requirements
- R1: The low two bits of `fetch_addr` are always 0.
- R2: While `rst` is high at a rising clock edge, the counter is cleared, so `fetch_addr` reads 0 after that edge.
- R3: When `jump` is low and `branch` and `alu_zero` are not both high, `fetch_addr` advances by 4 at each edge. This includes the cases where only one of `branch` and `alu_zero` is high, and it wraps from 0xFFFFFFFC to 0.
- R4: When `jump` is low and `branch` and `alu_zero` are both high, the next `fetch_addr` is `fetch_addr + 4 + 4*imm`. Here `imm` is `instr_word[15:0]` read as a two's complement number.
- R5: Branch arithmetic wraps modulo 2^32 with no overflow detection. Negative offsets move backward, and an offset below address 0 lands near 0xFFFFFFFC.
- R6: When `jump` is high, the next `fetch_addr` is built from three fields: bits [31:28] of the current `fetch_addr`, then `instr_word[25:0]`, then two zero bits.
- R7: `jump` takes priority over a taken branch when both are requested in the same cycle.
- R8: `instr_word` is the stored word at index `fetch_addr[7:2]`, read without a clock delay. A pulse on `ld_en` writes `ld_data` into index `ld_addr` at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the counter |
| branch | input | 1 | Conditional branch request |
| jump | input | 1 | Unconditional jump request |
| alu_zero | input | 1 | ALU equality flag |
| ld_en | input | 1 | Instruction store write enable |
| ld_addr | input | ROM_AW | Instruction store write index |
| ld_data | input | 32 | Instruction store write data |
| fetch_addr | output | 32 | Current fetch byte address |
| instr_word | output | 32 | Instruction at the current address |

## Verification
A corrupted counter bit shows on `fetch_addr` in the very next cycle. Because the store is read without a clock delay, the same wrong value reaches `instr_word` in that cycle too. A wrong selection of the next value appears one edge after the offending strobes. Arithmetic faults are exposed by two cases: a negative offset that crosses address zero, and a jump taken from the top of the address space. In both, a missing sign extension or a lost upper nibble changes the observed address at once.

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit #(
  parameter int ROM_AW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              branch,
  input  logic              jump,
  input  logic              alu_zero,
  input  logic              ld_en,
  input  logic [ROM_AW-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  output logic [31:0]       fetch_addr,
  output logic [31:0]       instr_word
);
  localparam int ROM_DEPTH = 1 << ROM_AW;
  localparam int WA = 30;

  logic [WA-1:0] pc_q;
  logic [WA-1:0] pc_seq, pc_br, pc_jmp, pc_nxt;
  logic [31:0]   rom [ROM_DEPTH];

  always_ff @(posedge clk)
    if (ld_en) rom[ld_addr] <= ld_data;

  assign instr_word = rom[pc_q[ROM_AW-1:0]];

  assign pc_seq = pc_q + WA'(1);
  assign pc_br  = pc_seq + {{(WA-16){instr_word[15]}}, instr_word[15:0]};
  assign pc_jmp = {pc_q[WA-1:WA-4], instr_word[25:0]};
  assign pc_nxt = jump ? pc_jmp : ((branch && alu_zero) ? pc_br : pc_seq);

  always_ff @(posedge clk)
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;

  assign fetch_addr = {pc_q, 2'b00};
endmodule

module fetch_pc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        branch,
  input logic        jump,
  input logic        alu_zero,
  input logic [31:0] fetch_addr,
  input logic [31:0] instr_word
);
  a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
    fetch_addr[1:0] == 2'b00);

  a_r2_reset_clears: assert property (@(posedge clk)
    rst |=> fetch_addr == 32'd0);

  a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
    (!jump && !(branch && alu_zero)) |=> fetch_addr == $past(fetch_addr) + 32'd4);

  a_r4_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (!jump && branch && alu_zero) |=>
      fetch_addr == $past(fetch_addr) + 32'd4 +
                    {{14{$past(instr_word[15])}}, $past(instr_word[15:0]), 2'b00});

  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    jump |=> fetch_addr == {$past(fetch_addr[31:28]), $past(instr_word[25:0]), 2'b00});
endmodule

bind fetch_pc_unit fetch_pc_unit_chk u_chk (
  .clk(clk), .rst(rst), .branch(branch), .jump(jump), .alu_zero(alu_zero),
  .fetch_addr(fetch_addr), .instr_word(instr_word)
);

// File: tb/tb_fetch_pc_unit.sv
module tb_fetch_pc_unit;
  localparam int AW = 6;

  logic clk = 0;
  logic rst = 1;
  logic branch = 0, jump = 0, alu_zero = 0, ld_en = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] fetch_addr, instr_word;
  logic [31:0] rom_m [1<<AW];
  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fetch_pc_unit #(.ROM_AW(AW)) dut (
    .clk(clk), .rst(rst), .branch(branch), .jump(jump), .alu_zero(alu_zero),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .fetch_addr(fetch_addr), .instr_word(instr_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [31:0] w);
    @(negedge clk);
    ld_en = 1; ld_addr = AW'(idx); ld_data = w;
    rom_m[idx] = w;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; branch = 0; jump = 0; alu_zero = 0;
    @(negedge clk);
    check("R2 reset", fetch_addr, 32'd0);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst = 0;
  endtask

  task automatic step(input logic b, input logic j, input logic z,
                      input logic [31:0] exp, input string req);
    branch = b; jump = j; alu_zero = z;
    @(posedge clk);
    @(negedge clk);
    check(req, fetch_addr, exp);
    check("R1 low bits", {30'd0, fetch_addr[1:0]}, 32'd0);
    check("R8 instr read", instr_word, rom_m[exp[7:2]]);
  endtask

  task automatic t_sequential();
    do_reset();
    for (int i = 0; i < (1<<AW); i++) load(i, 32'(i) * 32'h01010101);
    release_reset();
    step(0, 0, 0, 32'd4,  "R3 seq");
    step(0, 0, 0, 32'd8,  "R3 seq");
    step(1, 0, 0, 32'd12, "R3 branch without zero");
    step(0, 0, 1, 32'd16, "R3 zero without branch");
    do_reset();
    release_reset();
    step(0, 0, 0, 32'd4, "R2 restart");
  endtask

  task automatic t_branch();
    do_reset();
    load(0, 32'h0000_0005);
    load(6, 32'h0000_FFFD);
    release_reset();
    step(1, 0, 1, 32'd24, "R4 forward branch");
    step(1, 0, 1, 32'd16, "R5 backward branch");
  endtask

  task automatic t_wrap();
    do_reset();
    load(0, 32'h0000_FFFE);
    load(63, 32'h0000_0010);
    release_reset();
    step(1, 0, 1, 32'hFFFF_FFFC, "R5 wrap below zero");
    step(0, 0, 0, 32'h0000_0000, "R3 seq wrap");
    step(1, 0, 1, 32'hFFFF_FFFC, "R5 wrap again");
    step(0, 1, 0, 32'hF000_0040, "R6 jump keeps top nibble");
    step(0, 0, 0, 32'hF000_0044, "R3 seq after jump");
  endtask

  task automatic t_priority();
    do_reset();
    load(0, 32'h0200_0040);
    release_reset();
    step(1, 1, 1, 32'h0800_0100, "R7 jump over branch");
    do_reset();
    release_reset();
    step(0, 1, 0, 32'h0800_0100, "R6 jump alone");
  endtask

  task automatic t_runtime_load();
    do_reset();
    release_reset();
    step(0, 0, 0, 32'd4, "R3 seq");
    load(3, 32'hCAFE_0001);
    check("R8 runtime load", instr_word, 32'hCAFE_0001);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) rom_m[i] = '0;
    t_sequential();
    t_branch();
    t_wrap();
    t_priority();
    t_runtime_load();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule